// File: doc/BRIEF.md
# SPI Command Segment Sequencer

This block runs one segment of full-duplex SPI byte transfers per command word. Software or a local controller writes a small register set (control, chip-select ID, per-chip-select clock options, command), fills a byte-wide transmit queue, and issues a command that gives the number of bytes to exchange. For each byte, the sequencer takes the next byte from the transmit queue and shifts it out on `mosi`, most significant bit first. At the same time it samples `miso` and places the received byte in a receive queue that the user drains.

The sequencer reports through a small set of flags. `ready` shows that a new command may be issued. `active` shows that a segment is running. Two stall flags report why a segment ended early. A one-cycle error pulse reports a command that arrived while a segment was still running. The selected chip-select line is held low for the whole segment. The clock rate, polarity and phase come from the option set of the chip select that was chosen when the command was accepted.

Top module: `spi_seg_seq`

## Requirements
- R1: After reset, `ready`=1, `active`=0, all `cs_n` lines are high, `sclk`=0, both queues are empty, and both stall flags are 0.
- R2: The register address map is 0=control, 1=chip-select ID, 2=clock options, 3=command. A command word carries the byte count in bits 7:0. It is accepted only when control bit 31 (enable) is set and `ready` is 1. A command written while enable is clear has no effect: `ready` stays 1 and no byte leaves the transmit queue. A count of 0 exchanges no byte.
- R3: A command written while enabled and `ready`=0 raises `cmd_busy_err` for exactly one cycle, and the running segment continues unchanged.
- R4: Each exchanged byte is popped from the transmit queue and sent on `mosi` most significant bit first. The byte sampled from `miso` is pushed into the receive queue.
- R5: Clock-option bit 31 is the idle level of `sclk` (polarity), and bit 30 is the phase. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge. Between bytes and after a segment, `sclk` rests at the polarity level.
- R6: Clock-option bits 15:0 hold a divider D. Inside a byte, each half period of `sclk` lasts D+1 system clock cycles.
- R7: If the transmit queue is empty before a byte, `tx_stall` is set and the segment ends. The stall flags clear when the next command is accepted.
- R8: If the receive queue is full before a byte, `rx_stall` is set and the segment ends without losing received data.
- R9: When a segment ends, `ready` returns to 1, `active` to 0, and any bytes left in the transmit queue are discarded.
- R10: The chip-select ID register picks both the `cs_n` line and the option set that a command uses. Writing an ID of NUM_CS or more is ignored. Only the chosen line goes low, and only while `active`=1.
- R11: Writing control with bit 30 set returns all registers and both queues to their reset state, aborts any segment, clears `active` and clears the enable bit.
- R12: On the clock edge that accepts a command, `ready` falls and `active` rises together. They are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 chip-select ID, 2 clock options, 3 command) |
| reg_wdata | input | 32 | Register write data |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Remove the head byte of the receive queue |
| rx_data | output | 8 | Head byte of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| ready | output | 1 | A new command may be issued |
| active | output | 1 | A segment is running |
| tx_stall | output | 1 | Last segment ended on an empty transmit queue |
| rx_stall | output | 1 | Last segment ended on a full receive queue |
| cmd_busy_err | output | 1 | One-cycle pulse: command written while busy |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The hardest state to reach from the ports is a receive-full stall partway through a segment, followed by a discard of the unsent transmit bytes. The stimulus reaches it by queuing more transmit bytes than the receive queue can hold and then issuing a command for all of them without draining the receive side. It then checks the stall flag, the number of bytes kept, and that the transmit queue is empty. A second hard case is a software reset during a shift, which the bench triggers after a fixed delay into a slow segment. An inverted loopback from `mosi` to `miso`, together with an edge-accurate monitor of `mosi`, checks bit order, sampling phase and half-period length in all four clock modes.

// File: rtl/spi_seg_pkg.sv
package spi_seg_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CHECK = 2'd1,
    SQ_SHIFT = 2'd2,
    SQ_DONE  = 2'd3
  } seq_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CSID = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  localparam int CTRL_EN_BIT   = 31;
  localparam int CTRL_SRST_BIT = 30;
  localparam int CFG_CPOL_BIT  = 31;
  localparam int CFG_CPHA_BIT  = 30;

endpackage

// File: rtl/seg_fifo.sv
module seg_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (srst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/seg_shifter.sv
module seg_shifter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic             busy;
  logic [DIV_W-1:0] cnt;
  logic [3:0]       edge_n;
  logic [7:0]       txsr, rxsr;
  logic             sclk_q, done_q;

  assign sclk    = sclk_q;
  assign mosi    = txsr[7];
  assign done    = done_q;
  assign rx_byte = rxsr;

  always_ff @(posedge clk) begin
    if (srst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      edge_n <= '0;
      txsr   <= '0;
      rxsr   <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        sclk_q <= cpol;
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          edge_n <= '0;
          txsr   <= tx_byte;
        end
      end else if (cnt == div) begin
        cnt    <= '0;
        sclk_q <= ~sclk_q;
        edge_n <= edge_n + 4'd1;
        if (edge_n[0] == cpha)
          rxsr <= {rxsr[6:0], miso};
        else if (!(cpha && edge_n == 4'd0))
          txsr <= {txsr[6:0], 1'b0};
        if (edge_n == 4'd15) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_seg_seq.sv
module spi_seg_seq
  import spi_seg_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int DIV_W    = 16,
  parameter int LEN_W    = 8,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              tx_push,
  input  logic [7:0]        tx_data,
  output logic              tx_full,
  output logic              tx_empty,
  input  logic              rx_pop,
  output logic [7:0]        rx_data,
  output logic              rx_empty,
  output logic              ready,
  output logic              active,
  output logic              tx_stall,
  output logic              rx_stall,
  output logic              cmd_busy_err,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  // Soft reset: any control write with the reset bit acts like rst.
  logic srst, cmd_wr, accept, busy_hit;
  assign srst   = rst || (reg_we && reg_addr == ADDR_CTRL && reg_wdata[CTRL_SRST_BIT]);
  assign cmd_wr = reg_we && (reg_addr == ADDR_CMD);

  logic             en_q;
  logic [CS_W-1:0]  csid_q;
  logic [DIV_W-1:0] cfg_div  [NUM_CS];
  logic             cfg_cpol [NUM_CS];
  logic             cfg_cpha [NUM_CS];
  logic [NUM_CS-1:0] sel_n;

  always_ff @(posedge clk) begin
    if (srst) begin
      en_q   <= 1'b0;
      csid_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_CTRL) en_q <= reg_wdata[CTRL_EN_BIT];
      if (reg_addr == ADDR_CSID && reg_wdata < 32'(NUM_CS))
        csid_q <= reg_wdata[CS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      for (int i = 0; i < NUM_CS; i++) begin
        cfg_div[i]  <= '0;
        cfg_cpol[i] <= 1'b0;
        cfg_cpha[i] <= 1'b0;
      end
    end else if (reg_we && reg_addr == ADDR_CFG) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (csid_q == CS_W'(i)) begin
          cfg_div[i]  <= reg_wdata[DIV_W-1:0];
          cfg_cpol[i] <= reg_wdata[CFG_CPOL_BIT];
          cfg_cpha[i] <= reg_wdata[CFG_CPHA_BIT];
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_sel
      assign sel_n[g] = (csid_q != CS_W'(g));
    end
  endgenerate

  // Sequencer state
  seq_state_e        state;
  logic [LEN_W-1:0]  rem;
  logic [DIV_W-1:0]  seg_div;
  logic              seg_cpol, seg_cpha;
  logic              ready_q, active_q, txst_q, rxst_q, err_q;
  logic [NUM_CS-1:0] cs_n_q;

  logic       tx_pop, rx_push, tx_flush, sh_start, sh_done, sh_cpol;
  logic       tx_empty_w, rx_full_w;
  logic [7:0] tx_head, sh_rx;

  assign accept   = cmd_wr && en_q && ready_q && !srst;
  assign busy_hit = cmd_wr && en_q && !ready_q && !srst;
  assign sh_cpol  = accept ? cfg_cpol[csid_q] : seg_cpol;

  always_comb begin
    tx_pop   = 1'b0;
    sh_start = 1'b0;
    rx_push  = 1'b0;
    tx_flush = 1'b0;
    case (state)
      SQ_CHECK: if (rem != '0 && !tx_empty_w && !rx_full_w) begin
        tx_pop   = 1'b1;
        sh_start = 1'b1;
      end
      SQ_SHIFT: rx_push  = sh_done;
      SQ_DONE:  tx_flush = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      state    <= SQ_IDLE;
      rem      <= '0;
      seg_div  <= '0;
      seg_cpol <= 1'b0;
      seg_cpha <= 1'b0;
      ready_q  <= 1'b1;
      active_q <= 1'b0;
      txst_q   <= 1'b0;
      rxst_q   <= 1'b0;
      err_q    <= 1'b0;
      cs_n_q   <= '1;
    end else begin
      err_q <= busy_hit;
      case (state)
        SQ_IDLE: if (accept) begin
          state    <= SQ_CHECK;
          rem      <= reg_wdata[LEN_W-1:0];
          seg_div  <= cfg_div[csid_q];
          seg_cpol <= cfg_cpol[csid_q];
          seg_cpha <= cfg_cpha[csid_q];
          ready_q  <= 1'b0;
          active_q <= 1'b1;
          txst_q   <= 1'b0;
          rxst_q   <= 1'b0;
          cs_n_q   <= sel_n;
        end
        SQ_CHECK: begin
          if (rem == '0) begin
            state <= SQ_DONE;
          end else if (tx_empty_w) begin
            txst_q <= 1'b1;
            state  <= SQ_DONE;
          end else if (rx_full_w) begin
            rxst_q <= 1'b1;
            state  <= SQ_DONE;
          end else begin
            state <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: if (sh_done) begin
          rem   <= rem - 1'b1;
          state <= SQ_CHECK;
        end
        SQ_DONE: begin
          ready_q  <= 1'b1;
          active_q <= 1'b0;
          cs_n_q   <= '1;
          state    <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  seg_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .srst(srst), .push(tx_push), .pop(tx_pop), .flush(tx_flush),
    .wdata(tx_data), .rdata(tx_head), .full(tx_full), .empty(tx_empty_w)
  );

  seg_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .srst(srst), .push(rx_push), .pop(rx_pop), .flush(1'b0),
    .wdata(sh_rx), .rdata(rx_data), .full(rx_full_w), .empty(rx_empty)
  );

  seg_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .srst(srst), .start(sh_start), .tx_byte(tx_head),
    .cpol(sh_cpol), .cpha(seg_cpha), .div(seg_div), .miso(miso),
    .sclk(sclk), .mosi(mosi), .done(sh_done), .rx_byte(sh_rx)
  );

  assign tx_empty     = tx_empty_w;
  assign ready        = ready_q;
  assign active       = active_q;
  assign tx_stall     = txst_q;
  assign rx_stall     = rxst_q;
  assign cmd_busy_err = err_q;
  assign cs_n         = cs_n_q;
endmodule

// File: rtl/spi_seg_seq_chk.sv
module spi_seg_seq_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic              ready,
  input logic              active,
  input logic [NUM_CS-1:0] cs_n,
  input logic              cmd_busy_err,
  input logic              tx_stall,
  input logic              tx_empty
);
  p_ready_excl_r12: assert property (@(posedge clk) disable iff (rst)
    ready |-> !active);

  p_cs_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !active |-> (&cs_n));

  p_cs_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  p_busy_cause_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_busy_err |-> $past(reg_we && reg_addr == 2'd3 && !ready));

  p_ready_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(reg_we && reg_addr == 2'd3));

  p_stall_end_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_stall) |=> ready);

  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> tx_empty);
endmodule

bind spi_seg_seq spi_seg_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .ready(ready), .active(active), .cs_n(cs_n), .cmd_busy_err(cmd_busy_err),
  .tx_stall(tx_stall), .tx_empty(tx_empty)
);

// File: tb/sim_spi_seg_seq.sv
`timescale 1ns/1ps
module sim_spi_seg_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        tx_push = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        rx_pop = 1'b0;
  logic        tx_full, tx_empty, rx_empty, ready, active;
  logic        tx_stall, rx_stall, cmd_busy_err, sclk, mosi, miso;
  logic [7:0]  rx_data;
  logic [1:0]  cs_n;

  always #2.5 clk = ~clk;
  assign miso = ~mosi;

  spi_seg_seq u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_empty(rx_empty), .ready(ready), .active(active),
    .tx_stall(tx_stall), .rx_stall(rx_stall), .cmd_busy_err(cmd_busy_err),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0;
  int errors = 0;
  int err_cnt = 0;
  bit finished = 0;

  // {cs, cpol, cpha, div[4:0], nbytes[3:0], first byte[7:0]}
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 5'd0, 4'd3, 8'hA5},
    {1'b1, 1'b0, 1'b1, 5'd2, 4'd2, 8'h3C},
    {1'b0, 1'b1, 1'b0, 5'd1, 4'd4, 8'h81},
    {1'b1, 1'b1, 1'b1, 5'd4, 4'd1, 8'hF0},
    {1'b0, 1'b0, 1'b0, 5'd3, 4'd2, 8'h5A},
    {1'b1, 1'b1, 1'b0, 5'd0, 4'd4, 8'h0E}
  };

  // Edge monitor
  bit         mon_on = 0;
  logic       mon_cpol = 0, mon_cpha = 0;
  logic [7:0] mon_sr = '0;
  int         mon_bits = 0, cap_n = 0;
  logic [7:0] cap [16];
  real        last_t = -1.0, min_dt = 1.0e9;
  logic [1:0] cs_seen = '0;

  always @(sclk) begin
    if (mon_on) begin
      if (last_t >= 0.0 && ($realtime - last_t) < min_dt) min_dt = $realtime - last_t;
      last_t = $realtime;
      if ((sclk == 1'b1) == (mon_cpol == mon_cpha)) begin
        mon_sr = {mon_sr[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          if (cap_n < 16) cap[cap_n] = mon_sr;
          cap_n++;
          mon_bits = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (mon_on) cs_seen = cs_seen | ~cs_n;
    if (!rst && cmd_busy_err === 1'b1) err_cnt++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_push = 1'b1; tx_data = b;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    @(negedge clk);
    b = rx_data; rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int k = 0;
    @(negedge clk);
    while (!ready && k < 20000) begin
      @(negedge clk);
      k++;
    end
    chk(req, "ready after segment", {31'd0, ready}, 32'd1);
  endtask

  task automatic mon_start(input logic cp, input logic ch);
    cap_n = 0; mon_bits = 0; last_t = -1.0; min_dt = 1.0e9; cs_seen = '0;
    mon_cpol = cp; mon_cpha = ch;
  endtask

  initial begin
    #900us;
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", "ready", {31'd0, ready}, 32'd1);
    chk("R1", "active", {31'd0, active}, 32'd0);
    chk("R1", "cs_n", {30'd0, cs_n}, 32'd3);
    chk("R1", "sclk", {31'd0, sclk}, 32'd0);
    chk("R1", "queues empty", {30'd0, tx_empty, rx_empty}, 32'd3);
    chk("R1", "stalls", {30'd0, tx_stall, rx_stall}, 32'd0);

    // R2 command while disabled has no effect
    push_tx(8'h11); push_tx(8'h22);
    write_reg(2'd3, 32'd2);
    repeat (10) @(negedge clk);
    chk("R2", "ready disabled", {31'd0, ready}, 32'd1);
    chk("R2", "active disabled", {31'd0, active}, 32'd0);
    chk("R2", "tx kept disabled", {31'd0, tx_empty}, 32'd0);

    // R2 zero-length command; R9 leftover tx discarded
    write_reg(2'd0, 32'h8000_0000);
    write_reg(2'd3, 32'd0);
    wait_ready("R2");
    chk("R2", "zero length rx empty", {31'd0, rx_empty}, 32'd1);
    chk("R9", "flush after zero length", {31'd0, tx_empty}, 32'd1);

    // Vector walk: R4 R5 R6 R10
    for (int i = 0; i < 6; i++) begin
      logic [19:0] v;
      logic [4:0]  dv;
      logic [3:0]  n;
      logic [7:0]  sd;
      v = VEC[i]; dv = v[16:12]; n = v[11:8]; sd = v[7:0];
      write_reg(2'd1, {31'd0, v[19]});
      write_reg(2'd2, {v[18], v[17], 14'd0, 11'd0, dv});
      for (int k = 0; k < int'(n); k++) push_tx(sd + 8'(k));
      mon_start(v[18], v[17]);
      write_reg(2'd3, {28'd0, n});
      mon_on = 1;
      wait_ready("R4");
      mon_on = 0;
      chk("R4", "bytes on mosi", cap_n, {28'd0, n});
      for (int k = 0; k < int'(n); k++) begin
        chk("R4", "mosi byte msb first", {24'd0, cap[k]}, {24'd0, sd + 8'(k)});
        pop_rx(b);
        chk("R5", "rx byte sampled", {24'd0, b}, {24'd0, ~(sd + 8'(k))});
      end
      chk("R6", "half period x10ns", $rtoi(min_dt * 10.0 + 0.5), (int'(dv) + 1) * 50);
      chk("R5", "sclk idle level", {31'd0, sclk}, {31'd0, v[18]});
      chk("R10", "cs line used", {30'd0, cs_seen}, v[19] ? 32'd2 : 32'd1);
    end

    // R12 accept timing, R3 busy error
    write_reg(2'd1, 32'd0);
    write_reg(2'd2, 32'd7);
    push_tx(8'h96); push_tx(8'h69);
    err_cnt = 0;
    write_reg(2'd3, 32'd2);
    chk("R12", "ready low at accept", {31'd0, ready}, 32'd0);
    chk("R12", "active high at accept", {31'd0, active}, 32'd1);
    chk("R10", "cs0 low", {30'd0, cs_n}, 32'd2);
    write_reg(2'd3, 32'd2);
    wait_ready("R3");
    chk("R3", "busy pulses", err_cnt, 32'd1);
    pop_rx(b); chk("R3", "rx first", {24'd0, b}, 32'h69);
    pop_rx(b); chk("R3", "rx second", {24'd0, b}, 32'h96);
    chk("R3", "segment length kept", {31'd0, rx_empty}, 32'd1);

    // R7 tx stall
    push_tx(8'h3A);
    write_reg(2'd3, 32'd3);
    wait_ready("R7");
    chk("R7", "tx_stall", {31'd0, tx_stall}, 32'd1);
    chk("R7", "rx_stall", {31'd0, rx_stall}, 32'd0);
    pop_rx(b); chk("R7", "rx byte", {24'd0, b}, 32'hC5);
    chk("R7", "only one byte", {31'd0, rx_empty}, 32'd1);

    // R8 rx stall, R9 leftover flush
    for (int k = 0; k < 6; k++) push_tx(8'h40 + 8'(k));
    write_reg(2'd3, 32'd6);
    wait_ready("R8");
    chk("R8", "rx_stall", {31'd0, rx_stall}, 32'd1);
    chk("R7", "tx_stall cleared", {31'd0, tx_stall}, 32'd0);
    chk("R9", "leftover flushed", {31'd0, tx_empty}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      pop_rx(b);
      chk("R8", "kept byte", {24'd0, b}, {24'd0, ~(8'h40 + 8'(k))});
    end
    chk("R8", "four kept", {31'd0, rx_empty}, 32'd1);

    // R10 out-of-range ID ignored
    write_reg(2'd1, 32'd1);
    write_reg(2'd1, 32'd3);
    push_tx(8'h77);
    mon_start(1'b1, 1'b0);
    write_reg(2'd3, 32'd1);
    mon_on = 1;
    wait_ready("R10");
    mon_on = 0;
    chk("R10", "bad id ignored", {30'd0, cs_seen}, 32'd2);
    pop_rx(b); chk("R10", "rx byte", {24'd0, b}, 32'h88);

    // R11 software reset mid segment
    write_reg(2'd1, 32'd0);
    write_reg(2'd2, 32'd20);
    push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
    write_reg(2'd3, 32'd3);
    repeat (30) @(negedge clk);
    write_reg(2'd0, 32'h4000_0000);
    chk("R11", "ready", {31'd0, ready}, 32'd1);
    chk("R11", "active", {31'd0, active}, 32'd0);
    chk("R11", "cs_n", {30'd0, cs_n}, 32'd3);
    chk("R11", "queues", {30'd0, tx_empty, rx_empty}, 32'd3);
    chk("R11", "sclk", {31'd0, sclk}, 32'd0);
    push_tx(8'h55);
    write_reg(2'd3, 32'd1);
    repeat (5) @(negedge clk);
    chk("R11", "enable cleared ready", {31'd0, ready}, 32'd1);
    chk("R11", "enable cleared tx", {31'd0, tx_empty}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule